// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block arbitrates among sixteen interrupt request sources and names the single request that the processor should take next, together with the source index, the vector address and the priority level of that request. Each ordinary source is gated by its own enable bit and by a global enable. A per-source priority bit places the source at the low or the high level. One source, the power-fail source, sits alone at a third and highest level and is never masked.

One source slot is shared between an external interrupt line and a bus-master interrupt. A dedicated enable for the bus master decides which of the two drives the slot. A small tracker records which levels currently have a handler running. The processor pulses an acknowledge when it takes the offered request and a return when a handler ends. A request is offered only when its level is strictly above the level of the running handler.

Top module: `prio_irq_arbiter`

## Requirements
- R1: Source index 0 is the power-fail source. Whenever `req[0]` is 1 it is pending at level 3, whatever the values of `glob_en`, `en[0]` and `prio_hi[0]`.
- R2: Every source other than index 0 is pending only when its request and its own enable bit are 1 and `glob_en` is 1. With `glob_en` at 0 the only source that can be offered is index 0.
- R3: A pending source other than index 0 has level 2 when its `prio_hi` bit is 1 and level 1 when that bit is 0. `irq_level` reports the winner's level.
- R4: The winner is the pending source with the highest level. Among pending sources at that level, the lowest source index wins.
- R5: Slot 11 is shared. When `bm_en` is 1, slot 11 is pending exactly when `bm_req` is 1 (and `glob_en` is 1), and `req[11]` and `en[11]` have no effect. When `bm_en` is 0, slot 11 follows `req[11]` and `en[11]` like any other source, and `bm_req` has no effect.
- R6: `irq_vector` is 8'h03 + 8 × index for the winning index, except for indices 8 to 11, which all give 8'h43.
- R7: `irq_valid` is 1 only when a pending winner exists whose level is strictly greater than `active_level`. While `irq_valid` is 0, `irq_index`, `irq_vector` and `irq_level` are 0.
- R8: `active_level` is 0 after reset. On a clock edge where `irq_ack` and `irq_valid` are both 1, the offered level is marked active. If that does not happen and `irq_ret` is 1, the highest active level is cleared. `active_level` is the highest active level, or 0 when no level is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 16 | Request flags, one per source |
| en | input | 16 | Individual enable bits |
| prio_hi | input | 16 | Priority bits: 1 selects high, 0 selects low |
| glob_en | input | 1 | Global enable for all sources except power-fail |
| bm_req | input | 1 | Bus-master interrupt request |
| bm_en | input | 1 | Bus-master interrupt enable; gives it slot 11 |
| irq_ack | input | 1 | Processor takes the offered request |
| irq_ret | input | 1 | Processor returns from the running handler |
| irq_valid | output | 1 | A request is offered |
| irq_vector | output | 8 | Vector address of the offered request |
| irq_index | output | 4 | Source index of the offered request |
| irq_level | output | 2 | Level of the offered request (1 low, 2 high, 3 highest) |
| active_level | output | 2 | Highest level with a running handler, 0 if none |

## Verification
The bench builds the block with its default parameters: sixteen sources, power-fail at index 0, the shared slot at 11 and the common vector group covering indices 8 to 11. With these values every branch of the level map can be reached, including ties inside the vector group and the shared slot switching between its two owners. All three active levels can also be nested at once. A behavioural model written with integers follows the acknowledge and return pulses. It is compared with every output on each clock, first under directed cases and then under a long biased random run.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef logic [1:0] lvl_t;
   localparam lvl_t LVL_NONE = 2'd0;
   localparam lvl_t LVL_LOW  = 2'd1;
   localparam lvl_t LVL_HIGH = 2'd2;
   localparam lvl_t LVL_TOP  = 2'd3;
   localparam int   NUM_LVL  = 3;
endpackage

// File: rtl/irq_level_map.sv
module irq_level_map
   import irq_pkg::*;
#(
   parameter int NUM_SRC = 16,
   parameter int PF_IDX  = 0,
   parameter int SH_IDX  = 11
) (
   input  logic [NUM_SRC-1:0]      req,
   input  logic [NUM_SRC-1:0]      en,
   input  logic [NUM_SRC-1:0]      prio_hi,
   input  logic                    glob_en,
   input  logic                    bm_req,
   input  logic                    bm_en,
   output logic [NUM_SRC-1:0][1:0] lvl
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i == PF_IDX) begin : g_pf
         assign lvl[i] = req[i] ? LVL_TOP : LVL_NONE;
      end else if (i == SH_IDX) begin : g_shared
         logic pend;
         assign pend   = glob_en & (bm_en ? bm_req : (req[i] & en[i]));
         assign lvl[i] = pend ? (prio_hi[i] ? LVL_HIGH : LVL_LOW) : LVL_NONE;
      end else begin : g_plain
         logic pend;
         assign pend   = glob_en & req[i] & en[i];
         assign lvl[i] = pend ? (prio_hi[i] ? LVL_HIGH : LVL_LOW) : LVL_NONE;
      end
   end

   logic unused_pf_bits;
   assign unused_pf_bits = ^{en[PF_IDX], prio_hi[PF_IDX]};

   always_comb begin
      for (int k = 0; k < NUM_SRC; k++) begin
         if (k != PF_IDX)
            assert_gate_R2: assert (glob_en || lvl[k] == LVL_NONE);
      end
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
   import irq_pkg::*;
#(
   parameter int NUM_SRC = 16,
   localparam int IW     = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0][1:0] lvl,
   output logic                    found,
   output logic [IW-1:0]           idx,
   output lvl_t                    level
);
   logic [NUM_LVL:1]         hit;
   logic [NUM_LVL:1][IW-1:0] first;

   for (genvar g = 1; g <= NUM_LVL; g++) begin : g_lvl
      always_comb begin
         hit[g]   = 1'b0;
         first[g] = '0;
         for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (lvl[i] == lvl_t'(g)) begin
               hit[g]   = 1'b1;
               first[g] = IW'(i);
            end
         end
      end
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      level = LVL_NONE;
      for (int g = 1; g <= NUM_LVL; g++) begin
         if (hit[g]) begin
            found = 1'b1;
            idx   = first[g];
            level = lvl_t'(g);
         end
      end
   end

   always_comb begin
      if (found) begin
         assert_win_R4: assert (lvl[idx] == level);
      end
   end
endmodule

// File: rtl/irq_active_track.sv
module irq_active_track
   import irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic ret,
   input  lvl_t take_level,
   output lvl_t cur_level
);
   logic [NUM_LVL:1] active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= '0;
      end else if (take && take_level != LVL_NONE) begin
         active[take_level] <= 1'b1;
      end else if (ret && cur_level != LVL_NONE) begin
         active[cur_level] <= 1'b0;
      end
   end

   always_comb begin
      cur_level = LVL_NONE;
      for (int g = 1; g <= NUM_LVL; g++)
         if (active[g]) cur_level = lvl_t'(g);
   end

   assert_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> cur_level == $past(take_level));
   assert_ret_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && ret && cur_level != LVL_NONE) |=> cur_level < $past(cur_level));
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
   import irq_pkg::*;
#(
   parameter int NUM_SRC   = 16,
   parameter int PF_IDX    = 0,
   parameter int SH_IDX    = 11,
   parameter int GRP_LO    = 8,
   parameter int GRP_HI    = 11,
   parameter int VW        = 8,
   parameter int VEC_BASE  = 'h03,
   parameter int VEC_STEP  = 8,
   parameter int GRP_VEC   = 'h43,
   localparam int IW       = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req,
   input  logic [NUM_SRC-1:0] en,
   input  logic [NUM_SRC-1:0] prio_hi,
   input  logic               glob_en,
   input  logic               bm_req,
   input  logic               bm_en,
   input  logic               irq_ack,
   input  logic               irq_ret,
   output logic               irq_valid,
   output logic [VW-1:0]      irq_vector,
   output logic [IW-1:0]      irq_index,
   output logic [1:0]         irq_level,
   output logic [1:0]         active_level
);
   if (NUM_SRC < 2) begin : g_bad_n
      $error("NUM_SRC must be at least 2");
   end
   if (PF_IDX >= NUM_SRC || SH_IDX >= NUM_SRC || PF_IDX == SH_IDX) begin : g_bad_idx
      $error("PF_IDX and SH_IDX must be distinct valid indices");
   end
   if (GRP_LO > GRP_HI || GRP_HI >= NUM_SRC) begin : g_bad_grp
      $error("vector group range invalid");
   end
   if (VEC_BASE + VEC_STEP * (NUM_SRC - 1) >= (1 << VW) || GRP_VEC >= (1 << VW)) begin : g_bad_vec
      $error("vectors do not fit in VW bits");
   end

   logic [NUM_SRC-1:0][1:0] lvl;
   logic                    found;
   logic [IW-1:0]           win_idx;
   lvl_t                    win_level;
   lvl_t                    cur_level;
   logic [VW-1:0]           win_vec;

   irq_level_map #(.NUM_SRC(NUM_SRC), .PF_IDX(PF_IDX), .SH_IDX(SH_IDX)) u_map (
      .req(req), .en(en), .prio_hi(prio_hi), .glob_en(glob_en),
      .bm_req(bm_req), .bm_en(bm_en), .lvl(lvl));

   irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .lvl(lvl), .found(found), .idx(win_idx), .level(win_level));

   irq_active_track u_track (
      .clk(clk), .rst_n(rst_n), .take(irq_ack & irq_valid), .ret(irq_ret),
      .take_level(irq_level), .cur_level(cur_level));

   always_comb begin
      if (int'(win_idx) >= GRP_LO && int'(win_idx) <= GRP_HI)
         win_vec = VW'(GRP_VEC);
      else
         win_vec = VW'(VEC_BASE + VEC_STEP * int'(win_idx));
   end

   assign irq_valid    = found && (win_level > cur_level);
   assign irq_index    = irq_valid ? win_idx : '0;
   assign irq_level    = irq_valid ? win_level : LVL_NONE;
   assign irq_vector   = irq_valid ? win_vec : '0;
   assign active_level = cur_level;

   assert_pf_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req[PF_IDX] && active_level != LVL_TOP) |-> (irq_valid && int'(irq_index) == PF_IDX));
   assert_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && !glob_en) |-> int'(irq_index) == PF_IDX);
   assert_above_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> irq_level > active_level);
   assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid |-> (irq_vector == '0 && irq_index == '0 && irq_level == '0));
   assert_grpvec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && int'(irq_index) >= GRP_LO && int'(irq_index) <= GRP_HI)
         |-> irq_vector == VW'(GRP_VEC));
endmodule

// File: tb/prio_irq_arbiter_test.sv
module prio_irq_arbiter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] req = '0, en = '0, prio_hi = '0;
   logic        glob_en = 1'b0, bm_req = 1'b0, bm_en = 1'b0;
   logic        irq_ack = 1'b0, irq_ret = 1'b0;
   logic        irq_valid;
   logic [7:0]  irq_vector;
   logic [3:0]  irq_index;
   logic [1:0]  irq_level, active_level;

   int checks = 0;
   int errors = 0;
   int act[4];
   int e_valid, e_idx, e_lvl, e_vec, e_act;

   always #4 clk = ~clk;

   prio_irq_arbiter uut (
      .clk(clk), .rst_n(rst_n), .req(req), .en(en), .prio_hi(prio_hi),
      .glob_en(glob_en), .bm_req(bm_req), .bm_en(bm_en), .irq_ack(irq_ack),
      .irq_ret(irq_ret), .irq_valid(irq_valid), .irq_vector(irq_vector),
      .irq_index(irq_index), .irq_level(irq_level), .active_level(active_level));

   function automatic int src_level(int i);
      bit p;
      if (i == 0) return req[0] ? 3 : 0;
      if (i == 11 && bm_en) p = glob_en && bm_req;
      else p = glob_en && req[i] && en[i];
      if (!p) return 0;
      return prio_hi[i] ? 2 : 1;
   endfunction

   task automatic model();
      int best_l = 0, best_i = 0;
      e_act = 0;
      for (int g = 1; g <= 3; g++) if (act[g] != 0) e_act = g;
      for (int i = 0; i < 16; i++) begin
         int l = src_level(i);
         if (l > best_l) begin best_l = l; best_i = i; end
      end
      e_valid = (best_l > e_act) ? 1 : 0;
      e_idx = e_valid ? best_i : 0;
      e_lvl = e_valid ? best_l : 0;
      if (!e_valid) e_vec = 0;
      else if (best_i >= 8 && best_i <= 11) e_vec = 'h43;
      else e_vec = 3 + 8 * best_i;
   endtask

   task automatic cmp(string tag, int got, int exp, string what);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   // inputs are already set just after a negedge; check, then clock once
   task automatic step(string tag);
      #2;
      model();
      cmp(tag, int'(irq_valid), e_valid, "irq_valid");
      cmp(tag, int'(irq_index), e_idx, "irq_index");
      cmp(tag, int'(irq_level), e_lvl, "irq_level");
      cmp(tag, int'(irq_vector), e_vec, "irq_vector");
      cmp(tag, int'(active_level), e_act, "active_level");
      @(posedge clk);
      if (irq_ack && e_valid != 0) act[e_lvl] = 1;
      else if (irq_ret && e_act != 0) act[e_act] = 0;
      @(negedge clk);
   endtask

   task automatic clear_in();
      req = '0; en = '0; prio_hi = '0; glob_en = 1'b0;
      bm_req = 1'b0; bm_en = 1'b0; irq_ack = 1'b0; irq_ret = 1'b0;
   endtask

   initial begin
      #1600000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int g = 0; g < 4; g++) act[g] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step("R8 reset");
      // R1: power-fail with global and own enable cleared
      req[0] = 1'b1; step("R1");
      // R2: enabled source masked by glob_en, then by its own enable
      req = 16'h0010; en = 16'h0010; step("R2");
      glob_en = 1'b1; en = '0; step("R2");
      en = 16'h0010; step("R2");
      // R3: priority bit raises level
      req = 16'h0030; en = 16'h0030; prio_hi = 16'h0020; step("R3");
      // R4: tie at same level, lowest index wins; higher level beats index
      prio_hi = '0; req = 16'h8030; en = 16'hFFFF; step("R4");
      prio_hi = 16'h8000; step("R4");
      // R5: shared slot
      clear_in(); glob_en = 1'b1; en = 16'hFFFF;
      req[11] = 1'b1; bm_en = 1'b1; bm_req = 1'b0; step("R5 ext ignored");
      bm_req = 1'b1; req[11] = 1'b0; step("R5 bm");
      bm_en = 1'b0; step("R5 bm ignored");
      req[11] = 1'b1; step("R5 ext");
      // R6: vectors in and out of the group
      req = 16'h0100; step("R6"); req = 16'h8000; step("R6"); req = 16'h0080; step("R6");
      // R7/R8: nesting
      req = 16'h0004; irq_ack = 1'b1; step("R8 take low");
      irq_ack = 1'b0; step("R7 same level blocked");
      prio_hi = 16'h0002; req = 16'h0006; irq_ack = 1'b1; step("R8 take high");
      req[0] = 1'b1; step("R8 take pf");
      irq_ack = 1'b0; step("R7 all blocked");
      irq_ret = 1'b1; step("R8 ret"); step("R8 ret"); step("R8 ret"); step("R8 ret");
      clear_in();
      // random run
      for (int n = 0; n < 4000; n++) begin
         req = 16'($urandom) & 16'($urandom);
         req[0] = ($urandom % 8) == 0;
         en = 16'($urandom) | 16'($urandom);
         prio_hi = 16'($urandom);
         glob_en = ($urandom % 5) != 0;
         bm_req = 1'($urandom); bm_en = 1'($urandom);
         irq_ack = ($urandom % 3) == 0;
         irq_ret = ($urandom % 3) == 0;
         step("R4 random");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule